// File: doc/BRIEF.md
# Daughterboard GPIO Controller with Automatic Radio-State Patterns

This block drives 32 general-purpose pins toward a radio daughterboard. The pins form two 16-bit banks: the transmit bank on pin indices 31:16 and the receive bank on 15:0. Software programs the block through a small word-addressed register bus. Each pin has its own direction bit, and each output pin has its own 2-bit source field. The field picks the pin's level from one of four sources: a software data word, an automatic pattern that follows the radio state, or one of two 32-bit debug buses.

The automatic source holds four 32-bit pattern words, one for each radio state. The state comes from the `tx_active` and `rx_active` inputs. When transmit or receive activity starts or stops, the pins assigned to the automatic source switch to the matching pattern with no software involvement. Input levels on the pins are synchronized and can be read back over the bus.

Top module: `dbgpio_top`

## Requirements
- R1: After reset, every register reads zero, `pin_oe` is all zeros, `pin_out` is all zeros and `bus_rdata` is zero.
- R2: The data word sits at word address 0. Bit n drives pin n, with the transmit bank in bits 31:16 and the receive bank in bits 15:0. An output pin with source code 0 drives its data bit. The pin output reflects a bus write on the second rising edge after the write is presented.
- R3: The direction word sits at address 1, and a 1 in bit n makes pin n an output. `pin_oe` equals the direction word one edge after that word is updated.
- R4: The radio state is {tx_active, rx_active}: 00 idle, 10 transmit only, 01 receive only, 11 full duplex. An output pin with source code 1 drives the same bit of the pattern word for the current state. It follows a state change on the next rising edge.
- R5: Source code 2 drives the pin from the same bit of `dbg0`, and code 3 drives it from the same bit of `dbg1`. A pin follows a debug input change on the next rising edge.
- R6: Address 2 holds the source fields for the transmit bank: pin 16+k uses bits 2k+1:2k. Address 3 holds the fields for the receive bank: pin k uses bits 2k+1:2k. Each pin decodes its own field independently of the other pins.
- R7: The pattern words sit at addresses 4 (idle), 5 (transmit only), 6 (receive only) and 7 (full duplex).
- R8: A read of address 0 returns the pin input levels after a two-flop synchronizer. A level applied to `pin_in` appears in a read issued two cycles later, and not in a read issued one cycle later.
- R9: A read of addresses 1 to 7 returns the stored word, with `bus_rdata` valid one edge after `bus_rd`. A write to any address above 7 changes no register, and a read there returns zero.
- R10: A pin whose direction bit is 0 has `pin_out` at 0, whatever its source field selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| tx_active | input | 1 | Transmit path is active |
| rx_active | input | 1 | Receive path is active |
| dbg0 | input | 32 | First debug bus |
| dbg1 | input | 32 | Second debug bus |
| pin_in | input | 32 | Sampled pin levels |
| pin_out | output | 32 | Pin output levels |
| pin_oe | output | 32 | Pin output enables |

## Verification
Results arrive at different delays depending on the stimulus. A register write reaches `pin_out` and `pin_oe` two edges after it is presented. A change on the radio-state or debug inputs reaches the pins one edge later. A read returns data one edge after the strobe. A pin input level needs two further edges in the synchronizer before a read can capture it. Each driver task records the cycle in which it drives its stimulus and pushes the expected value into a queue, tagged with that cycle plus the matching delay. The monitor compares each entry only in that cycle, sampling on the falling edge. Stimuli are spaced so that no later stimulus disturbs an output before its check is due. One read is placed deliberately one cycle too early to confirm that the synchronizer delay is not shorter than required.

// File: rtl/dbgpio_pkg.sv
package dbgpio_pkg;
    parameter int BANK_W     = 16;
    parameter int SEL_W      = 2;
    parameter int NUM_STATES = 4;
    parameter int ADDR_W     = 4;

    localparam int PIN_W    = 2 * BANK_W;
    localparam int SELREG_W = BANK_W * SEL_W;
    localparam int STIDX_W  = $clog2(NUM_STATES);

    // word addresses
    localparam int ADR_DATA   = 0;
    localparam int ADR_DIR    = 1;
    localparam int ADR_SEL_TX = 2;
    localparam int ADR_SEL_RX = 3;
    localparam int ADR_PAT0   = 4;
    localparam int ADR_LAST   = ADR_PAT0 + NUM_STATES - 1;

    typedef enum logic [SEL_W-1:0] {
        SRC_SW   = 2'd0,
        SRC_AUTO = 2'd1,
        SRC_DBG0 = 2'd2,
        SRC_DBG1 = 2'd3
    } src_e;

    typedef enum logic [STIDX_W-1:0] {
        ST_IDLE   = 2'd0,
        ST_TXONLY = 2'd1,
        ST_RXONLY = 2'd2,
        ST_DUPLEX = 2'd3
    } radio_st_e;

    typedef struct packed {
        logic [PIN_W-1:0]                  data;
        logic [PIN_W-1:0]                  dir;
        logic [SELREG_W-1:0]               sel_tx;
        logic [SELREG_W-1:0]               sel_rx;
        logic [NUM_STATES-1:0][PIN_W-1:0]  pat;
    } cfg_t;
endpackage

// File: rtl/dbgpio_sync.sv
module dbgpio_sync
    import dbgpio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIN_W-1:0] pin_in,
    output logic [PIN_W-1:0] pin_sync
);
    typedef struct packed {
        logic [PIN_W-1:0] meta;
        logic [PIN_W-1:0] stable;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.meta   = pin_in;
        s_d.stable = s_q.meta;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pin_sync = s_q.stable;

    // R8: the synchronized level is the input of two edges earlier
    p_sync_two_stage_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n, 2) |-> pin_sync == $past(pin_in, 2));
endmodule

// File: rtl/dbgpio_regs.sv
module dbgpio_regs
    import dbgpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PIN_W-1:0]  wdata,
    input  logic [PIN_W-1:0]  pin_sync,
    output logic [PIN_W-1:0]  rdata,
    output cfg_t              cfg
);
    typedef struct packed {
        cfg_t             cfg;
        logic [PIN_W-1:0] rdata;
    } regs_t;

    regs_t s_d, s_q;

    logic               in_pat;
    logic [ADDR_W-1:0]  pat_off;
    logic [STIDX_W-1:0] pat_idx;

    always_comb begin
        in_pat  = (int'(addr) >= ADR_PAT0) && (int'(addr) <= ADR_LAST);
        pat_off = addr - ADDR_W'(ADR_PAT0);
        pat_idx = pat_off[STIDX_W-1:0];
    end

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            if (int'(addr) == ADR_DATA)        s_d.cfg.data   = wdata;
            else if (int'(addr) == ADR_DIR)    s_d.cfg.dir    = wdata;
            else if (int'(addr) == ADR_SEL_TX) s_d.cfg.sel_tx = wdata[SELREG_W-1:0];
            else if (int'(addr) == ADR_SEL_RX) s_d.cfg.sel_rx = wdata[SELREG_W-1:0];
            else if (in_pat)                   s_d.cfg.pat[pat_idx] = wdata;
        end
        if (rd_en) begin
            if (int'(addr) == ADR_DATA)        s_d.rdata = pin_sync;
            else if (int'(addr) == ADR_DIR)    s_d.rdata = s_q.cfg.dir;
            else if (int'(addr) == ADR_SEL_TX) s_d.rdata = PIN_W'(s_q.cfg.sel_tx);
            else if (int'(addr) == ADR_SEL_RX) s_d.rdata = PIN_W'(s_q.cfg.sel_rx);
            else if (in_pat)                   s_d.rdata = s_q.cfg.pat[pat_idx];
            else                               s_d.rdata = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rdata = s_q.rdata;
    assign cfg   = s_q.cfg;

    // R2: a write to the data word lands on the next edge
    p_data_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(addr) == ADR_DATA) |=> cfg.data == $past(wdata));

    // R9: writes outside the map leave every register untouched
    p_bad_addr_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(addr) > ADR_LAST) |=> $stable(cfg));
endmodule

// File: rtl/dbgpio_state_pat.sv
module dbgpio_state_pat
    import dbgpio_pkg::*;
(
    input  logic                             tx_active,
    input  logic                             rx_active,
    input  logic [NUM_STATES-1:0][PIN_W-1:0] pat,
    output logic [PIN_W-1:0]                 pat_now
);
    radio_st_e st;

    always_comb begin
        unique case ({tx_active, rx_active})
            2'b10:   st = ST_TXONLY;
            2'b01:   st = ST_RXONLY;
            2'b11:   st = ST_DUPLEX;
            default: st = ST_IDLE;
        endcase
        pat_now = pat[st];
    end
endmodule

// File: rtl/dbgpio_pinmux.sv
module dbgpio_pinmux
    import dbgpio_pkg::*;
(
    input  cfg_t             cfg,
    input  logic [PIN_W-1:0] pat_now,
    input  logic [PIN_W-1:0] dbg0,
    input  logic [PIN_W-1:0] dbg1,
    output logic [PIN_W-1:0] out_d,
    output logic [PIN_W-1:0] oe_d
);
    for (genvar g = 0; g < PIN_W; g++) begin : g_pin
        logic [SEL_W-1:0] field;
        logic             lvl;

        if (g >= BANK_W) begin : g_tx
            assign field = cfg.sel_tx[(g-BANK_W)*SEL_W +: SEL_W];
        end else begin : g_rx
            assign field = cfg.sel_rx[g*SEL_W +: SEL_W];
        end

        always_comb begin
            unique case (src_e'(field))
                SRC_SW:   lvl = cfg.data[g];
                SRC_AUTO: lvl = pat_now[g];
                SRC_DBG0: lvl = dbg0[g];
                default:  lvl = dbg1[g];
            endcase
        end

        // a pin that is not an output keeps its level low
        assign out_d[g] = cfg.dir[g] & lvl;
        assign oe_d[g]  = cfg.dir[g];
    end
endmodule

// File: rtl/dbgpio_top.sv
module dbgpio_top
    import dbgpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PIN_W-1:0]  bus_wdata,
    output logic [PIN_W-1:0]  bus_rdata,
    input  logic              tx_active,
    input  logic              rx_active,
    input  logic [PIN_W-1:0]  dbg0,
    input  logic [PIN_W-1:0]  dbg1,
    input  logic [PIN_W-1:0]  pin_in,
    output logic [PIN_W-1:0]  pin_out,
    output logic [PIN_W-1:0]  pin_oe
);
    typedef struct packed {
        logic [PIN_W-1:0] out;
        logic [PIN_W-1:0] oe;
    } drv_t;

    logic [PIN_W-1:0] pin_sync;
    logic [PIN_W-1:0] pat_now;
    logic [PIN_W-1:0] out_d;
    logic [PIN_W-1:0] oe_d;
    cfg_t             cfg;
    drv_t             drv_d, drv_q;

    dbgpio_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .pin_sync (pin_sync)
    );

    dbgpio_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr),
        .rd_en    (bus_rd),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .pin_sync (pin_sync),
        .rdata    (bus_rdata),
        .cfg      (cfg)
    );

    dbgpio_state_pat u_pat (
        .tx_active (tx_active),
        .rx_active (rx_active),
        .pat       (cfg.pat),
        .pat_now   (pat_now)
    );

    dbgpio_pinmux u_mux (
        .cfg     (cfg),
        .pat_now (pat_now),
        .dbg0    (dbg0),
        .dbg1    (dbg1),
        .out_d   (out_d),
        .oe_d    (oe_d)
    );

    always_comb begin
        drv_d     = drv_q;
        drv_d.out = out_d;
        drv_d.oe  = oe_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) drv_q <= '0;
        else        drv_q <= drv_d;
    end

    assign pin_out = drv_q.out;
    assign pin_oe  = drv_q.oe;

    // R3: output enables follow the stored direction word one edge later
    p_oe_follows_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> pin_oe == $past(cfg.dir));

    // R10: pins that are not outputs never show a high level
    p_inputs_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~pin_oe) == '0);
endmodule

// File: tb/sim_dbgpio_top.sv
module sim_dbgpio_top;
    import dbgpio_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [PIN_W-1:0]  bus_wdata = '0;
    logic [PIN_W-1:0]  bus_rdata;
    logic              tx_active = 1'b0;
    logic              rx_active = 1'b0;
    logic [PIN_W-1:0]  dbg0 = '0;
    logic [PIN_W-1:0]  dbg1 = '0;
    logic [PIN_W-1:0]  pin_in = '0;
    logic [PIN_W-1:0]  pin_out;
    logic [PIN_W-1:0]  pin_oe;

    dbgpio_top u0 (
        .clk, .rst_n, .bus_wr, .bus_rd, .bus_addr, .bus_wdata, .bus_rdata,
        .tx_active, .rx_active, .dbg0, .dbg1, .pin_in, .pin_out, .pin_oe
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_checks = 0;
    int n_fails  = 0;

    typedef struct {
        int               due;
        int               kind;   // 0 pin_out, 1 pin_oe, 2 bus_rdata
        logic [PIN_W-1:0] exp;
        string            tag;
    } item_t;

    item_t sb[$];

    // reference model state
    logic [PIN_W-1:0] m_data, m_dir, m_seltx, m_selrx;
    logic [PIN_W-1:0] m_pat [NUM_STATES];
    logic [PIN_W-1:0] m_sync_view;

    function automatic logic [PIN_W-1:0] model_out();
        logic [PIN_W-1:0] r = '0;
        int st = (tx_active && rx_active) ? 3 : tx_active ? 1 : rx_active ? 2 : 0;
        for (int i = 0; i < PIN_W; i++) begin
            logic [1:0] f;
            if (i >= BANK_W) f = m_seltx[(i-BANK_W)*2 +: 2];
            else             f = m_selrx[i*2 +: 2];
            if (m_dir[i]) begin
                case (f)
                    2'd0: r[i] = m_data[i];
                    2'd1: r[i] = m_pat[st][i];
                    2'd2: r[i] = dbg0[i];
                    default: r[i] = dbg1[i];
                endcase
            end
        end
        return r;
    endfunction

    task automatic compare(int kind, logic [PIN_W-1:0] exp, string tag);
        logic [PIN_W-1:0] act = (kind == 0) ? pin_out : (kind == 1) ? pin_oe : bus_rdata;
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s (kind %0d): actual %h expected %h", tag, kind, act, exp);
        end
    endtask

    task automatic push(int lat, int kind, logic [PIN_W-1:0] exp, string tag);
        item_t it;
        it.due = cyc + lat; it.kind = kind; it.exp = exp; it.tag = tag;
        sb.push_back(it);
    endtask

    // monitor: compares due items on the falling edge
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].due == cyc) begin
                compare(sb[i].kind, sb[i].exp, sb[i].tag);
                sb.delete(i);
            end
        end
        if (cyc > WATCHDOG) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    task automatic bus_write(int a, logic [PIN_W-1:0] d, string tag);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
        case (a)
            ADR_DATA:   m_data  = d;
            ADR_DIR:    m_dir   = d;
            ADR_SEL_TX: m_seltx = d;
            ADR_SEL_RX: m_selrx = d;
            default: if (a >= ADR_PAT0 && a <= ADR_LAST) m_pat[a-ADR_PAT0] = d;
        endcase
        push(2, 0, model_out(), tag);
        push(2, 1, m_dir, tag);
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(int a, logic [PIN_W-1:0] exp, string tag);
        @(posedge clk); #1;
        bus_rd = 1'b1; bus_addr = ADDR_W'(a);
        push(1, 2, exp, tag);
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic set_state(logic tx, logic rx, string tag);
        @(posedge clk); #1;
        tx_active = tx; rx_active = rx;
        push(1, 0, model_out(), tag);
        @(posedge clk); #1;
    endtask

    task automatic set_dbg(logic [PIN_W-1:0] d0, logic [PIN_W-1:0] d1, string tag);
        @(posedge clk); #1;
        dbg0 = d0; dbg1 = d1;
        push(1, 0, model_out(), tag);
        @(posedge clk); #1;
    endtask

    initial begin
        m_data = '0; m_dir = '0; m_seltx = '0; m_selrx = '0;
        for (int i = 0; i < NUM_STATES; i++) m_pat[i] = '0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        compare(0, '0, "R1 pin_out after reset");
        compare(1, '0, "R1 pin_oe after reset");
        compare(2, '0, "R1 rdata after reset");
        bus_read(ADR_DIR, '0, "R1 dir reads zero");
        bus_read(ADR_PAT0 + 3, '0, "R1 pattern reads zero");

        // R10: data written while all pins are inputs stays off the pins
        bus_write(ADR_DATA, 32'hA5A5_5A5A, "R10 inputs stay low");
        // R2/R3: all outputs, software source
        bus_write(ADR_DIR, 32'hFFFF_FFFF, "R2 R3 software data on pins");
        bus_write(ADR_DIR, 32'hFF00_00FF, "R3 R10 partial direction");
        bus_read(ADR_DIR, 32'hFF00_00FF, "R9 direction readback");
        bus_write(ADR_DIR, 32'hFFFF_FFFF, "R3 all outputs again");

        // R7: pattern words
        bus_write(ADR_PAT0 + 0, 32'h1111_2222, "R7 idle pattern");
        bus_write(ADR_PAT0 + 1, 32'h3333_4444, "R7 tx pattern");
        bus_write(ADR_PAT0 + 2, 32'h5555_6666, "R7 rx pattern");
        bus_write(ADR_PAT0 + 3, 32'h7777_8888, "R7 duplex pattern");
        bus_read(ADR_PAT0 + 2, 32'h5555_6666, "R7 rx pattern readback");

        // R4: every pin on the automatic source, walk all states
        bus_write(ADR_SEL_TX, 32'h5555_5555, "R4 tx bank auto");
        bus_write(ADR_SEL_RX, 32'h5555_5555, "R4 idle pattern on pins");
        set_state(1'b1, 1'b0, "R4 transmit only");
        set_state(1'b0, 1'b1, "R4 receive only");
        set_state(1'b1, 1'b1, "R4 full duplex");
        set_state(1'b0, 1'b0, "R4 back to idle");

        // R5: debug buses
        set_dbg(32'hDEAD_BEEF, 32'h0123_4567, "R5 debug values set");
        bus_write(ADR_SEL_TX, 32'hAAAA_AAAA, "R5 tx bank debug0");
        bus_write(ADR_SEL_RX, 32'hFFFF_FFFF, "R5 rx bank debug1");
        set_dbg(32'h0F0F_F0F0, 32'hCAFE_D00D, "R5 debug change follows");

        // R6: per-pin fields, mixed sources
        bus_write(ADR_SEL_RX, 32'h0000_0039, "R6 rx pins 0..2 mixed");
        bus_write(ADR_SEL_TX, 32'hC000_0001, "R6 tx pin16 auto pin31 dbg1");
        set_state(1'b1, 1'b1, "R6 R4 mixed under duplex");

        // R9: out-of-map writes and reads
        bus_write(9, 32'hFFFF_FFFF, "R9 bad write no effect");
        bus_read(9, '0, "R9 bad read zero");
        bus_read(ADR_SEL_RX, 32'h0000_0039, "R9 select unchanged");
        bus_read(ADR_DATA + 0, '0, "R8 pins idle");

        // R8: synchronizer delay on read-back
        @(posedge clk); #1;
        pin_in = 32'h1234_8765;
        bus_read(ADR_DATA, '0, "R8 one cycle is too early");
        bus_read(ADR_DATA, 32'h1234_8765, "R8 synchronized pins");

        repeat (4) @(posedge clk);
        @(negedge clk);
        if (sb.size() != 0) begin
            n_checks++;
            n_fails++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule